// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block keeps the rest of the chip in reset after a power-on, a brown-out or a wake from sleep until a chain of time-outs has run to completion. The chain has up to three phases, always in this order: a power-up delay counted in prescaled ticks of a slow free-running RC oscillator, a start-up count of oscillator clock cycles that lets a crystal settle, and a lock wait for the frequency multiplier, also counted in slow ticks. Which phases run depends on the oscillator mode code and on what started the sequence.

The block runs on the oscillator clock. The slow oscillator reaches it as a one-cycle strobe, `rc_tick`, already synchronised to `clk`. All delays are parameters given in ticks or cycles. The power-on pulse is the block's asynchronous reset. The external reset pin and a brown-out both hold the output high, but the pin does not stop the timers.

Top module: `por_sequencer`

## Requirements
- R1: While `pwr_on` is high, `chip_rst` is high. After it falls, the sequence starts from the power-on cause.
- R2: On power-on and after a brown-out, the power-up delay runs first when `pup_en` is 1. It lasts `PUP_PRE*PUP_LEN` rising edges with `rc_tick` high. When `pup_en` is 0 it is skipped.
- R3: The oscillator start-up count lasts `OSC_LEN` clock cycles. It runs only in the crystal modes (`osc_mode` 0, 1, 2 and 3) and only for a power-on or a wake cause. It follows the power-up delay.
- R4: In mode 3 (crystal with multiplier), a lock wait of `LOCK_LEN` `rc_tick` strobes follows the preceding phase for every cause.
- R5: In modes 4 to 7 with `pup_en` 0, `chip_rst` falls at the first clock edge after `pwr_on` falls.
- R6: While `brown` is high, `chip_rst` is high and all counting stops. When it clears, the sequence restarts with the brown-out cause and runs no start-up count.
- R7: A brown-out that arrives during the power-up delay restarts that delay from zero.
- R8: `ext_rst_n` low holds `chip_rst` high but does not pause the phases. If the chain has already finished, `chip_rst` falls at the first edge after the pin goes high.
- R9: A `wake` strobe is acted on only once the chain is complete, and is ignored while a sequence runs. A wake skips the power-up delay. In modes 4 to 7 it raises `chip_rst` for exactly one cycle.
- R10: `chip_rst` is a register. It falls at the same edge at which the last enabled phase completes, and it is high whenever a phase, a brown-out or the pin is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| pwr_on | input | 1 | Power-on pulse, asynchronous reset, active high |
| brown | input | 1 | Brown-out detected, active high |
| ext_rst_n | input | 1 | External reset pin, active low |
| wake | input | 1 | One-cycle wake-from-sleep event |
| osc_mode | input | 3 | Oscillator mode: 0-2 crystal, 3 crystal with multiplier, 4-7 RC or external clock |
| pup_en | input | 1 | Power-up delay enable |
| rc_tick | input | 1 | Synchronised strobe from the slow RC oscillator |
| chip_rst | output | 1 | Chip reset, active high |

## Verification
The hardest situations to reach are a brown-out that lands part-way through the power-up delay, and a pin release that comes after the timers have expired. Both depend on where the chain stands at a given moment, and that can only be inferred from the ports. The bench drives `rc_tick` itself at a fixed period, so it knows the tick phase. It then raises `brown` a chosen number of cycles into the delay, and holds `ext_rst_n` low past the end of the chain. A cycle-level expectation model, written as remaining-count phases, follows every edge. Seeded random mixes of brown-outs, wake strobes and pin toggles cover the orderings in between.

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int CW       = 10,
  parameter int PUP_PRE  = 8,
  parameter int PUP_LEN  = 1000,
  parameter int OSC_LEN  = 1024,
  parameter int LOCK_LEN = 256
) (
  input  logic       clk,
  input  logic       pwr_on,
  input  logic       brown,
  input  logic       ext_rst_n,
  input  logic       wake,
  input  logic [2:0] osc_mode,
  input  logic       pup_en,
  input  logic       rc_tick,
  output logic       chip_rst
);
  localparam int PW = (PUP_PRE > 1) ? $clog2(PUP_PRE) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(PUP_PRE - 1);
  localparam logic [CW-1:0] PUP_LAST  = CW'(PUP_LEN - 1);
  localparam logic [CW-1:0] OSC_LAST  = CW'(OSC_LEN - 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_LEN - 1);

  typedef enum logic [2:0] {S_BROWN, S_START, S_PUP, S_OSC, S_LOCK, S_DONE} state_t;
  typedef enum logic [1:0] {C_POWER, C_BROWN, C_WAKE} cause_t;

  state_t        st, st_n;
  cause_t        cause, cause_n;
  logic [PW-1:0] pre, pre_n;
  logic [CW-1:0] cnt, cnt_n;

  wire crystal   = ~osc_mode[2];
  wire mult_mode = (osc_mode == 3'd3);

  state_t after_osc, after_pup, first_phase;
  assign after_osc   = mult_mode ? S_LOCK : S_DONE;
  assign after_pup   = (crystal && cause != C_BROWN) ? S_OSC : after_osc;
  assign first_phase = (cause != C_WAKE && pup_en) ? S_PUP : after_pup;

  always_comb begin
    st_n    = st;
    cause_n = cause;
    pre_n   = pre;
    cnt_n   = cnt;
    if (brown) begin
      st_n  = S_BROWN;
      pre_n = '0;
      cnt_n = '0;
    end else if (wake && st == S_DONE) begin
      st_n    = S_START;
      cause_n = C_WAKE;
    end else begin
      case (st)
        S_BROWN: begin
          st_n    = S_START;
          cause_n = C_BROWN;
        end
        S_START: st_n = first_phase;
        S_PUP: if (rc_tick) begin
          if (pre == PRE_LAST) begin
            pre_n = '0;
            if (cnt == PUP_LAST) begin
              cnt_n = '0;
              st_n  = after_pup;
            end else cnt_n = cnt + 1'b1;
          end else pre_n = pre + 1'b1;
        end
        S_OSC: begin
          if (cnt == OSC_LAST) begin
            cnt_n = '0;
            st_n  = after_osc;
          end else cnt_n = cnt + 1'b1;
        end
        S_LOCK: if (rc_tick) begin
          if (cnt == LOCK_LAST) begin
            cnt_n = '0;
            st_n  = S_DONE;
          end else cnt_n = cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or posedge pwr_on) begin
    if (pwr_on) begin
      st       <= S_START;
      cause    <= C_POWER;
      pre      <= '0;
      cnt      <= '0;
      chip_rst <= 1'b1;
    end else begin
      st       <= st_n;
      cause    <= cause_n;
      pre      <= pre_n;
      cnt      <= cnt_n;
      chip_rst <= brown | ~ext_rst_n | (st_n != S_DONE);
    end
  end

  assert_brown_holds_R6: assert property (@(posedge clk) disable iff (pwr_on)
    brown |=> chip_rst);
  assert_brown_restarts_R7: assert property (@(posedge clk) disable iff (pwr_on)
    brown |=> (st == S_BROWN && cnt == '0));
  assert_pin_holds_R8: assert property (@(posedge clk) disable iff (pwr_on)
    !ext_rst_n |=> chip_rst);
  assert_osc_crystal_only_R3: assert property (@(posedge clk) disable iff (pwr_on)
    (st == S_OSC) |-> (crystal && cause != C_BROWN));
  assert_osc_bound_R3: assert property (@(posedge clk) disable iff (pwr_on)
    (st == S_OSC) |-> (cnt <= OSC_LAST));
  assert_lock_mode_only_R4: assert property (@(posedge clk) disable iff (pwr_on)
    (st == S_LOCK) |-> mult_mode);
  assert_no_pup_on_wake_R9: assert property (@(posedge clk) disable iff (pwr_on)
    (cause == C_WAKE) |-> (st != S_PUP));
  assert_release_done_R10: assert property (@(posedge clk) disable iff (pwr_on)
    $fell(chip_rst) |-> (st == S_DONE));
endmodule

// File: tb/sim_por_sequencer.sv
`timescale 1ns/1ps
module sim_por_sequencer;
  localparam int PRE = 2, PLEN = 4, OLEN = 16, LLEN = 3, TP = 3;

  logic clk = 1'b0;
  logic pwr_on = 1'b1, brown = 1'b0, ext_rst_n = 1'b1, wake = 1'b0;
  logic [2:0] osc_mode = 3'd2;
  logic pup_en = 1'b1, rc_tick = 1'b0;
  logic chip_rst;

  por_sequencer #(.CW(10), .PUP_PRE(PRE), .PUP_LEN(PLEN), .OSC_LEN(OLEN), .LOCK_LEN(LLEN)) u0 (
    .clk(clk), .pwr_on(pwr_on), .brown(brown), .ext_rst_n(ext_rst_n), .wake(wake),
    .osc_mode(osc_mode), .pup_en(pup_en), .rc_tick(rc_tick), .chip_rst(chip_rst));

  always #2.5 clk = ~clk;

  int total = 0, failed = 0, bad = 0, tcnt = 0;
  logic bad_act, bad_exp, done_flag = 1'b0;

  // expectation model: phases 0 brown,1 start,2 pup,3 osc,4 lock,5 done; cause 0 power,1 brown,2 wake
  int mph = 1, mcause = 0, mleft = 0;
  logic mexp = 1'b1;

  task automatic to_done_or_lock();
    if (osc_mode == 3'd3) begin mph = 4; mleft = LLEN; end
    else mph = 5;
  endtask
  task automatic after_delay();
    if (!osc_mode[2] && mcause != 1) begin mph = 3; mleft = OLEN; end
    else to_done_or_lock();
  endtask
  task automatic model_step();
    if (pwr_on) begin mph = 1; mcause = 0; mexp = 1'b1; return; end
    if (brown) mph = 0;
    else if (wake && mph == 5) begin mph = 1; mcause = 2; end
    else case (mph)
      0: begin mph = 1; mcause = 1; end
      1: if (mcause != 2 && pup_en) begin mph = 2; mleft = PRE * PLEN; end else after_delay();
      2: if (rc_tick) begin if (mleft == 1) after_delay(); else mleft--; end
      3: if (mleft == 1) to_done_or_lock(); else mleft--;
      4: if (rc_tick) begin if (mleft == 1) mph = 5; else mleft--; end
      default: ;
    endcase
    mexp = brown | ~ext_rst_n | (mph != 5);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    #2;
    if (chip_rst !== mexp) begin
      if (bad == 0) begin bad_act = chip_rst; bad_exp = mexp; end
      bad++;
    end
    tcnt = (tcnt == TP - 1) ? 0 : tcnt + 1;
    rc_tick = (tcnt == 0);
  endtask

  task automatic chk(string req, logic act, logic expv);
    total++;
    if (act !== expv) begin
      failed++;
      $display("FAIL %s chip_rst actual=%0b expected=%0b", req, act, expv);
    end
  endtask

  task automatic seg(string req, int n);
    bad = 0;
    repeat (n) cycle();
    total++;
    if (bad != 0) begin
      failed++;
      $display("FAIL %s %0d cycles differ, first actual=%0b expected=%0b", req, bad, bad_act, bad_exp);
    end
  endtask

  task automatic power(logic [2:0] m, logic en);
    pwr_on = 1'b1; osc_mode = m; pup_en = en; brown = 1'b0; wake = 1'b0; ext_rst_n = 1'b1;
    repeat (3) cycle();
    pwr_on = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1; cycle(); wake = 1'b0;
  endtask

  initial begin
    int seed = 7;
    int r;
    r = $urandom(seed);
    // R1 reset state
    repeat (4) cycle();
    chk("R1 held during power-on", chip_rst, 1'b1);

    power(3'd2, 1'b1); seg("R2 R3 crystal power-on chain", 80);
    chk("R10 released after chain", chip_rst, 1'b0);
    power(3'd3, 1'b1); seg("R4 multiplier mode chain", 100);
    power(3'd0, 1'b0); seg("R3 crystal without delay", 40);
    power(3'd6, 1'b1); seg("R2 external clock delay only", 50);

    power(3'd4, 1'b0); cycle();
    chk("R5 immediate release", chip_rst, 1'b0);
    seg("R5 stays released", 10);

    power(3'd1, 1'b1); seg("R2 setup", 80);
    brown = 1'b1; seg("R6 held during brown-out", 6);
    brown = 1'b0; seg("R6 rerun delay without start-up", 60);

    brown = 1'b1; repeat (3) cycle(); brown = 1'b0;
    seg("R7 first delay part", 14);
    brown = 1'b1; cycle(); brown = 1'b0;
    seg("R7 restarted delay", 60);

    power(3'd3, 1'b1); seg("R4 setup", 100);
    brown = 1'b1; cycle(); brown = 1'b0;
    seg("R4 lock wait after brown-out", 60);

    pwr_on = 1'b1; osc_mode = 3'd2; pup_en = 1'b1; ext_rst_n = 1'b0;
    repeat (3) cycle(); pwr_on = 1'b0;
    seg("R8 pin low while timers run", 100);
    ext_rst_n = 1'b1; cycle();
    chk("R8 release after expiry", chip_rst, 1'b0);

    power(3'd2, 1'b1); seg("R8 partial", 10);
    ext_rst_n = 1'b0; cycle(); ext_rst_n = 1'b1;
    seg("R8 early release waits for chain", 70);

    pulse_wake(); seg("R9 crystal wake", 30);
    osc_mode = 3'd3; pulse_wake(); seg("R9 multiplier wake", 40);
    power(3'd6, 1'b1); seg("R9 setup", 40);
    pulse_wake();
    chk("R9 one-cycle pulse high", chip_rst, 1'b1);
    cycle();
    chk("R9 one-cycle pulse low", chip_rst, 1'b0);
    power(3'd2, 1'b1); seg("R9 before wake", 5);
    pulse_wake(); seg("R9 wake ignored mid-sequence", 70);

    for (int k = 0; k < 20; k++) begin
      power(3'($urandom % 8), 1'($urandom % 2));
      bad = 0;
      for (int c = 0; c < 150; c++) begin
        r = $urandom % 100;
        brown = (r < 3) ? 1'b1 : (brown && r < 70);
        wake = (r >= 96);
        if (r >= 3 && r < 5) ext_rst_n = ~ext_rst_n;
        cycle();
      end
      wake = 1'b0; brown = 1'b0; ext_rst_n = 1'b1;
      total++;
      if (bad != 0) begin
        failed++;
        $display("FAIL R10 random mix %0d: %0d cycles differ, first actual=%0b expected=%0b", k, bad, bad_act, bad_exp);
      end
    end

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #750000;
    if (!done_flag) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule